// File: doc/BRIEF.md
# Oversampled Video Bus Phase Picker

This block takes a slow parallel video bus (twelve colour bits, horizontal sync, vertical sync and display enable) that is launched by an external pixel clock. It samples every pin with a fast clock that runs at a fixed multiple of the data rate. A data period of `PERIOD` fast cycles (16 by default: a 256 MHz fast clock against a 16 MHz pixel stream) holds `PERIOD` candidate sample positions. For each period the block keeps one sample per pin group, taken at a chosen position, so that data is captured well clear of its transitions. The block then presents the re-timed bus together with a one-cycle sample strobe in the fast domain.

The control group (the two syncs and display enable) and the colour group each have their own capture position, because the two groups can arrive with different skew. A position is either written directly on a per-group request input or, in automatic mode, found by the block. In automatic mode the block counts, per position, how often the group's pins change over a window of periods. It then samples half a period away from the busiest edge position.

Top module: `vid_phase_capture`

## Requirements
- R1: While reset is asserted and until the first strobe, every capture output and the strobe are low. The position counter reads 0 on the first rising edge after reset is released.
- R2: The position counter advances by one on every fast edge and wraps after `PERIOD` counts. `cap_stb` is high for exactly one fast cycle, directly after each edge at which the position was `PERIOD-1`. It is never high at any other time.
- R3: Each pin passes through a two-stage synchronizer. The value kept for position p is the pin level that was present at the edge two positions earlier.
- R4: With `auto_en` low, the control group is sampled at the position given by `phase_sync_req` and the colour group at the position given by `phase_rgb_req`. The samples appear on the outputs with the next strobe. Control bits map as `cap_hs`, `cap_vs`, `cap_de`. The colour bits keep their pin order.
- R5: The two groups use independent positions. A position of one group never changes what the other group captures.
- R6: A new position request is adopted only at the end-of-period edge, and it applies from the following period. A request that changes mid-period does not alter the sample of the current period. A capture position of `PERIOD-1` is honoured in the same cycle as the output transfer.
- R7: Between strobes all capture outputs hold their values.
- R8: With `auto_en` high, each group counts the fast cycles in which any of its synchronized bits changed, one counter per position, over `WIN_PERIODS` periods. At the end of the window the group selects the busiest position plus `PERIOD/2`, modulo `PERIOD`, and adopts it at a later period boundary.
- R9: When two positions have equal counts in automatic mode, the lower position is taken as the busiest.
- R10: With `auto_en` high, the values on `phase_sync_req` and `phase_rgb_req` have no effect on what is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Oversampling clock, `PERIOD` cycles per data period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_rgb | input | 3*COLOR_W | Colour pins from the source (12 by default) |
| pin_hs | input | 1 | Horizontal sync pin |
| pin_vs | input | 1 | Vertical sync pin |
| pin_de | input | 1 | Display enable pin |
| auto_en | input | 1 | 1 = positions found from observed edges, 0 = positions from the request inputs |
| phase_sync_req | input | $clog2(PERIOD) | Requested capture position for the control group |
| phase_rgb_req | input | $clog2(PERIOD) | Requested capture position for the colour group |
| cap_rgb | output | 3*COLOR_W | Re-timed colour word |
| cap_hs | output | 1 | Re-timed horizontal sync |
| cap_vs | output | 1 | Re-timed vertical sync |
| cap_de | output | 1 | Re-timed display enable |
| cap_stb | output | 1 | One-cycle strobe marking new re-timed values |

## Verification
The tricky coincidence is a group sampling at position `PERIOD-1`. In that same cycle the period-end transfer copies held samples to the outputs and reloads both positions. The bench provokes it by moving the colour position to 15 in the middle of a period, while the control position moves to 14 and the pins change on every fast cycle. A scoreboard model that tracks pin history per edge predicts exactly which edge's value must appear. A stale hold value or a sample one cycle off therefore shows up as a data mismatch on the next strobe.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

   // Position half a period away from a given edge position, wrapping.
   function automatic int unsigned far_phase(input int unsigned edge_pos,
                                             input int unsigned period);
      return (edge_pos + period / 2) % period;
   endfunction

endpackage

// File: rtl/vpc_sync.sv
module vpc_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   // STAGES synchronizer flops plus one more for change detection
   logic [W-1:0] stg_q [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i <= STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q      = stg_q[STAGES-1];
   assign q_prev = stg_q[STAGES];
endmodule

// File: rtl/vpc_edge_hist.sv
module vpc_edge_hist import vpc_pkg::*; #(
   parameter int unsigned PERIOD      = 16,
   parameter int unsigned WIN_PERIODS = 32,
   localparam int unsigned PW = $clog2(PERIOD),
   localparam int unsigned CW = $clog2(WIN_PERIODS + 1),
   localparam int unsigned WW = (WIN_PERIODS > 1) ? $clog2(WIN_PERIODS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] pos,
   input  logic          period_end,
   input  logic          edge_seen,
   output logic [PW-1:0] pick
);
   logic [CW-1:0] bin_q [PERIOD];
   logic [WW-1:0] win_q;
   logic          win_last;
   logic [CW-1:0] best_cnt;
   logic [PW-1:0] best_idx;
   logic [PW-1:0] pick_q;

   assign win_last = (win_q == WW'(WIN_PERIODS - 1));

   // busiest position; strict compare keeps the lowest on ties
   always_comb begin
      best_cnt = '0;
      best_idx = '0;
      for (int i = 0; i < PERIOD; i++) begin
         if (bin_q[i] > best_cnt) begin
            best_cnt = bin_q[i];
            best_idx = PW'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PERIOD; i++) bin_q[i] <= '0;
         win_q  <= '0;
         pick_q <= PW'(PERIOD / 2);
      end else begin
         for (int i = 0; i < PERIOD; i++) begin
            if (period_end && win_last)
               bin_q[i] <= (edge_seen && pos == PW'(i)) ? CW'(1) : '0;
            else if (edge_seen && pos == PW'(i) && bin_q[i] != '1)
               bin_q[i] <= bin_q[i] + CW'(1);
         end
         if (period_end) begin
            win_q <= win_last ? '0 : win_q + WW'(1);
            if (win_last && best_cnt != '0)
               pick_q <= PW'(far_phase(32'(best_idx), PERIOD));
         end
      end
   end

   assign pick = pick_q;
endmodule

// File: rtl/vpc_lane.sv
module vpc_lane #(
   parameter int unsigned W      = 1,
   parameter int unsigned PERIOD = 16,
   localparam int unsigned PW = $clog2(PERIOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] pos,
   input  logic          period_end,
   input  logic [PW-1:0] sel_phase,
   input  logic [W-1:0]  d,
   output logic [PW-1:0] act_phase,
   output logic [W-1:0]  q
);
   logic [W-1:0]  hold_q;
   logic [W-1:0]  out_q;
   logic [PW-1:0] act_q;
   logic          hit;

   assign hit = (pos == act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         out_q  <= '0;
         act_q  <= '0;
      end else begin
         if (hit) hold_q <= d;
         if (period_end) begin
            out_q <= hit ? d : hold_q;
            act_q <= sel_phase;
         end
      end
   end

   assign act_phase = act_q;
   assign q         = out_q;
endmodule

// File: rtl/vid_phase_capture.sv
module vid_phase_capture #(
   parameter int unsigned COLOR_W     = 4,
   parameter int unsigned PERIOD      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned WIN_PERIODS = 32,
   parameter bit          HAS_AUTO    = 1'b1
) (
   input  logic                       clk_fast,
   input  logic                       rst_n,
   input  logic [3*COLOR_W-1:0]       pin_rgb,
   input  logic                       pin_hs,
   input  logic                       pin_vs,
   input  logic                       pin_de,
   input  logic                       auto_en,
   input  logic [$clog2(PERIOD)-1:0]  phase_sync_req,
   input  logic [$clog2(PERIOD)-1:0]  phase_rgb_req,
   output logic [3*COLOR_W-1:0]       cap_rgb,
   output logic                       cap_hs,
   output logic                       cap_vs,
   output logic                       cap_de,
   output logic                       cap_stb
);
   localparam int unsigned PW     = $clog2(PERIOD);
   localparam int unsigned RGB_W  = 3 * COLOR_W;
   localparam int unsigned CTRL_W = 3;

   if (PERIOD < 4 || (PERIOD & (PERIOD - 1)) != 0) begin : g_bad_period
      $error("PERIOD must be a power of two, at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WIN_PERIODS < 1) begin : g_bad_win
      $error("WIN_PERIODS must be at least 1");
   end
   if (COLOR_W < 1) begin : g_bad_color
      $error("COLOR_W must be at least 1");
   end

   logic [PW-1:0]     pos_q;
   logic              period_end;
   logic              stb_q;
   logic [CTRL_W-1:0] s_ctrl, s_ctrl_prev;
   logic [RGB_W-1:0]  s_rgb, s_rgb_prev;
   logic [PW-1:0]     pick_ctrl, pick_rgb;
   logic [PW-1:0]     sel_ctrl, sel_rgb;
   logic [PW-1:0]     act_ctrl, act_rgb;
   logic [CTRL_W-1:0] q_ctrl;
   logic [RGB_W-1:0]  q_rgb;

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         stb_q <= 1'b0;
      end else begin
         pos_q <= pos_q + PW'(1);
         stb_q <= period_end;
      end
   end

   assign period_end = (pos_q == PW'(PERIOD - 1));

   vpc_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync_ctrl (
      .clk(clk_fast), .rst_n(rst_n), .d({pin_de, pin_vs, pin_hs}),
      .q(s_ctrl), .q_prev(s_ctrl_prev)
   );

   vpc_sync #(.W(RGB_W), .STAGES(SYNC_STAGES)) u_sync_rgb (
      .clk(clk_fast), .rst_n(rst_n), .d(pin_rgb),
      .q(s_rgb), .q_prev(s_rgb_prev)
   );

   if (HAS_AUTO) begin : g_auto
      vpc_edge_hist #(.PERIOD(PERIOD), .WIN_PERIODS(WIN_PERIODS)) u_hist_ctrl (
         .clk(clk_fast), .rst_n(rst_n), .pos(pos_q), .period_end(period_end),
         .edge_seen(|(s_ctrl ^ s_ctrl_prev)), .pick(pick_ctrl)
      );
      vpc_edge_hist #(.PERIOD(PERIOD), .WIN_PERIODS(WIN_PERIODS)) u_hist_rgb (
         .clk(clk_fast), .rst_n(rst_n), .pos(pos_q), .period_end(period_end),
         .edge_seen(|(s_rgb ^ s_rgb_prev)), .pick(pick_rgb)
      );
      assign sel_ctrl = auto_en ? pick_ctrl : phase_sync_req;
      assign sel_rgb  = auto_en ? pick_rgb  : phase_rgb_req;
   end else begin : g_fixed
      assign pick_ctrl = phase_sync_req;
      assign pick_rgb  = phase_rgb_req;
      assign sel_ctrl  = phase_sync_req;
      assign sel_rgb   = phase_rgb_req;
   end

   vpc_lane #(.W(CTRL_W), .PERIOD(PERIOD)) u_lane_ctrl (
      .clk(clk_fast), .rst_n(rst_n), .pos(pos_q), .period_end(period_end),
      .sel_phase(sel_ctrl), .d(s_ctrl), .act_phase(act_ctrl), .q(q_ctrl)
   );

   vpc_lane #(.W(RGB_W), .PERIOD(PERIOD)) u_lane_rgb (
      .clk(clk_fast), .rst_n(rst_n), .pos(pos_q), .period_end(period_end),
      .sel_phase(sel_rgb), .d(s_rgb), .act_phase(act_rgb), .q(q_rgb)
   );

   assign cap_rgb = q_rgb;
   assign cap_hs  = q_ctrl[0];
   assign cap_vs  = q_ctrl[1];
   assign cap_de  = q_ctrl[2];
   assign cap_stb = stb_q;
endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
   parameter int unsigned PERIOD = 16,
   parameter int unsigned PW     = 4,
   parameter int unsigned RGB_W  = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PW-1:0]    pos,
   input logic             auto_en,
   input logic [PW-1:0]    req_ctrl,
   input logic [PW-1:0]    req_rgb,
   input logic [PW-1:0]    pick_ctrl,
   input logic [PW-1:0]    pick_rgb,
   input logic [PW-1:0]    act_ctrl,
   input logic [PW-1:0]    act_rgb,
   input logic [RGB_W-1:0] cap_rgb,
   input logic [2:0]       cap_ctrl,
   input logic             cap_stb
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          armed_q <= 1'b0;
      else if (pos == PW'(PERIOD - 1))     armed_q <= 1'b1;
   end

   p_stb_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |-> (pos == '0));

   p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> !cap_stb);

   p_stb_every_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && pos == '0) |-> cap_stb);

   p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_stb |-> ($stable(cap_rgb) && $stable(cap_ctrl)));

   p_phase_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pos != '0) |-> ($stable(act_ctrl) && $stable(act_rgb)));

   p_manual_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && pos == '0 && !$past(auto_en)) |->
         (act_ctrl == $past(req_ctrl) && act_rgb == $past(req_rgb)));

   p_auto_ignores_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && pos == '0 && $past(auto_en)) |->
         (act_ctrl == $past(pick_ctrl) && act_rgb == $past(pick_rgb)));
endmodule

bind vid_phase_capture vpc_checker #(.PERIOD(PERIOD), .PW(PW), .RGB_W(RGB_W)) chk_i (
   .clk(clk_fast), .rst_n(rst_n), .pos(pos_q), .auto_en(auto_en),
   .req_ctrl(phase_sync_req), .req_rgb(phase_rgb_req),
   .pick_ctrl(pick_ctrl), .pick_rgb(pick_rgb),
   .act_ctrl(act_ctrl), .act_rgb(act_rgb),
   .cap_rgb(cap_rgb), .cap_ctrl({cap_de, cap_vs, cap_hs}), .cap_stb(cap_stb)
);

// File: tb/vid_phase_capture_tb_top.sv
`timescale 1ns/1ps
module vid_phase_capture_tb_top;
   localparam int P   = 16;
   localparam int WIN = 32;

   typedef struct {
      bit         valid;
      logic [2:0] c;
      logic [11:0] r;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] pin_rgb;
   logic        pin_hs, pin_vs, pin_de;
   logic        auto_en;
   logic [3:0]  req_s, req_r;
   logic [11:0] cap_rgb;
   logic        cap_hs, cap_vs, cap_de, cap_stb;

   int n_checks = 0;
   int n_fail   = 0;
   int eidx     = -1;
   int mode     = 0;
   bit skip     = 1'b0;
   int exp_s    = 0;
   int exp_r    = 0;
   string tag   = "R1";
   exp_t q[$];
   logic [14:0] ring [64];
   int m_act_s = 0, m_act_r = 0;
   logic [2:0]  m_hold_s = '0;
   logic [11:0] m_hold_r = '0;
   logic [2:0]  last_c = '0;
   logic [11:0] last_r = '0;
   logic [2:0]  w_c = '0;
   logic [11:0] w_r = '0;

   always #2 clk = ~clk;

   vid_phase_capture dut_i (
      .clk_fast(clk), .rst_n(rst_n), .pin_rgb(pin_rgb), .pin_hs(pin_hs),
      .pin_vs(pin_vs), .pin_de(pin_de), .auto_en(auto_en),
      .phase_sync_req(req_s), .phase_rgb_req(req_r),
      .cap_rgb(cap_rgb), .cap_hs(cap_hs), .cap_vs(cap_vs), .cap_de(cap_de),
      .cap_stb(cap_stb)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   task automatic wait_pos(input int p);
      do @(negedge clk); while ((eidx % P) != p);
   endtask

   initial for (int i = 0; i < 64; i++) ring[i] = '0;

   // reference model: pin history per edge, two-edge latency, period-end transfer
   always @(posedge clk) begin
      if (rst_n) begin
         int p;
         logic [14:0] old;
         eidx++;
         p = eidx % P;
         ring[eidx % 64] = {pin_de, pin_vs, pin_hs, pin_rgb};
         old = ring[(eidx + 62) % 64];
         if (p == m_act_s) m_hold_s = old[14:12];
         if (p == m_act_r) m_hold_r = old[11:0];
         if (p == P - 1) begin
            exp_t it;
            it.valid = !skip;
            it.c = m_hold_s;
            it.r = m_hold_r;
            q.push_back(it);
            m_act_s = auto_en ? exp_s : int'(req_s);
            m_act_r = auto_en ? exp_r : int'(req_r);
         end
      end
   end

   // pin driver
   always @(negedge clk) begin
      if (rst_n && eidx >= 0) begin
         int nxt;
         nxt = (eidx + 1) % P;
         case (mode)
            0: begin
               pin_rgb = 12'((eidx + 1) * 37);
               {pin_de, pin_vs, pin_hs} = 3'(((eidx + 1) * 5) >> 1);
            end
            1: begin
               if (nxt == 3) w_c = w_c + 3'd1;
               if (nxt == 9) w_r = w_r + 12'd1;
               {pin_de, pin_vs, pin_hs} = w_c;
               pin_rgb = w_r;
            end
            default: begin
               if (nxt == 3) w_c = w_c + 3'd1;
               if (nxt == 4 || nxt == 12) w_r = w_r + 12'd1;
               {pin_de, pin_vs, pin_hs} = w_c;
               pin_rgb = w_r;
            end
         endcase
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (cap_stb) begin
            if (q.size() == 0) begin
               check(1'b0, "R2 strobe without a period end", 16'(cap_stb), 16'h0);
            end else begin
               exp_t it;
               it = q.pop_front();
               if (it.valid) begin
                  check({cap_de, cap_vs, cap_hs} == it.c, {tag, " control group"},
                        16'({cap_de, cap_vs, cap_hs}), 16'(it.c));
                  check(cap_rgb == it.r, {tag, " colour group"},
                        16'(cap_rgb), 16'(it.r));
               end
            end
            last_c = {cap_de, cap_vs, cap_hs};
            last_r = cap_rgb;
         end else begin
            check(q.size() == 0, "R2 missing strobe", 16'(q.size()), 16'h0);
            check(cap_rgb == last_r && {cap_de, cap_vs, cap_hs} == last_c,
                  "R7 output held between strobes",
                  16'(cap_rgb), 16'(last_r));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; auto_en = 1'b0; req_s = '0; req_r = '0;
      pin_rgb = '0; pin_hs = 1'b0; pin_vs = 1'b0; pin_de = 1'b0;
      repeat (3) @(negedge clk);
      check(cap_stb == 1'b0, "R1 strobe low in reset", 16'(cap_stb), 16'h0);
      check(cap_rgb == '0 && {cap_de, cap_vs, cap_hs} == '0,
            "R1 outputs clear in reset", 16'(cap_rgb), 16'h0);
      rst_n = 1'b1;
      // manual positions, pins change every fast cycle
      tag = "R3 R4 R5";
      req_s = 4'd5; req_r = 4'd11;
      repeat (20 * P) @(negedge clk);
      // mid-period change, colour position on the period-end cycle
      wait_pos(6);
      tag = "R6";
      req_s = 4'd14; req_r = 4'd15;
      repeat (10 * P) @(negedge clk);
      wait_pos(6);
      req_s = 4'd0; req_r = 4'd8;
      repeat (6 * P) @(negedge clk);
      // automatic positions
      skip = 1'b1; mode = 1; exp_s = 13; exp_r = 3; auto_en = 1'b1;
      tag = "R8";
      repeat (4 * WIN * P) @(negedge clk);
      wait_pos(0);
      skip = 1'b0;
      repeat (20 * P) @(negedge clk);
      tag = "R10";
      req_s = 4'd3; req_r = 4'd9;
      repeat (10 * P) @(negedge clk);
      req_s = 4'd12; req_r = 4'd2;
      repeat (10 * P) @(negedge clk);
      // equal counts at two positions
      skip = 1'b1; mode = 2; exp_r = 14;
      tag = "R9";
      repeat (4 * WIN * P) @(negedge clk);
      wait_pos(0);
      skip = 1'b0;
      repeat (20 * P) @(negedge clk);
      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule